// File: doc/BRIEF.md
# Thermal Threshold Throttle Controller

The block takes a 7-bit die temperature sample in whole degrees Celsius. It registers the sample once and compares the registered value against three programmable limits. The two throttle limits form a two-step ladder. When the lower limit is reached, the block holds back a downstream activity strobe for a large share of every window: either half of the window or nine tenths of it, chosen by a policy bit. When the upper limit is reached, the strobe is held back for every cycle. The third limit is a trip point. Reaching it raises a fatal shutdown request for a board-level controller, and the request stays raised until the next reset.

Software reaches the block through a flat 64-bit register port. One register holds the limits, their enables, the policy bit and the two live comparison flags. A second register returns the registered temperature. A third register reports whether automatic throttling is built into this instance. That choice is made at build time, and an instance built without throttling never blocks the strobe.

Top module: `therm_throttle`

## Requirements
- R1: After reset every limit, enable and the policy bit read as 0, `throttleOn` is 0 and `fatalReq` is 0.
- R2: At byte offset 0x08 the lower limit sits in bits 6:0 with its enable in bit 7, the upper limit in bits 14:8 with its enable in bit 15, the trip limit in bits 30:24 and the policy bit in bit 44. These fields read back what was written. Written values in the other bits, including 32 and 33, are ignored, and those bits other than 32 and 33 read 0.
- R3: Bit 32 of offset 0x08 reads 1 exactly when the registered temperature is at or above the lower limit. Bit 33 does the same for the upper limit. Both bits ignore the enables, do not latch, and change one cycle after a new `tempIn` value is applied.
- R4: Offset 0x10 returns the registered temperature in bits 6:0 and 0 elsewhere. Writes to it are ignored.
- R5: Offset 0x20 bit 0 reads 1 when the instance is built without throttling, and in that case `throttleOn` never asserts. Writes to it are ignored.
- R6: With the lower limit enabled and reached, the upper level inactive and policy 0, `throttleOn` is high in exactly 9 of every 10 consecutive cycles.
- R7: Under the same conditions with policy 1, `throttleOn` is high in exactly 5 of every 10 consecutive cycles.
- R8: With the upper limit enabled and reached, `throttleOn` is high in every cycle, whatever the lower limit and the policy are.
- R9: A limit whose enable bit is 0 adds no throttling, even when it is reached.
- R10: With a nonzero trip limit, `fatalReq` rises one cycle after a sample at or above that limit is applied. A trip limit of 0 never raises it.
- R11: Once raised, `fatalReq` stays at 1 until reset, even after the temperature falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tempIn | input | 7 | Temperature sample, whole degrees Celsius |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data for `regAddr`, combinational |
| throttleOn | output | 1 | High in cycles in which downstream activity must be blocked |
| fatalReq | output | 1 | Sticky shutdown request |

## Verification
The trip event and full-rate throttling can start in the same cycle. This happens when one sample jumps from below both limits to above both the upper limit and the trip limit. The bench applies exactly such a step. It then requires `fatalReq` and `throttleOn` to both be high on the first cycle after the step and on no earlier cycle, and it requires blocking to cover all ten cycles of the window that follows. When the temperature then drops below every limit, the bench requires the throttling to stop while the fatal request stays raised.

// File: rtl/tht_pkg.sv
package tht_pkg;
  // register layout (field positions are decoded by software)
  localparam int TEMP_W     = 7;
  localparam int OFS_LIMITS = 8'h08;
  localparam int OFS_SENSOR = 8'h10;
  localparam int OFS_CAP    = 8'h20;
  localparam int LO_LSB     = 0;
  localparam int LO_EN_BIT  = 7;
  localparam int HI_LSB     = 8;
  localparam int HI_EN_BIT  = 15;
  localparam int TRIP_LSB   = 24;
  localparam int LO_ST_BIT  = 32;
  localparam int HI_ST_BIT  = 33;
  localparam int POL_BIT    = 44;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_HALF  = 2'd1,
    LVL_HEAVY = 2'd2,
    LVL_FULL  = 2'd3
  } throttleLevel_t;

  // strobes from the datapath to the control
  typedef struct packed {
    logic loReached;
    logic hiReached;
    logic tripReached;
    logic loEnable;
    logic hiEnable;
    logic policyHalf;
  } cmpFlags_t;
endpackage

// File: rtl/tht_datapath.sv
module tht_datapath
  import tht_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter bit NO_THROTTLE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output cmpFlags_t         cmpFlags
);
  localparam logic [ADDR_W-1:0] ADR_LIMITS = ADDR_W'(OFS_LIMITS);
  localparam logic [ADDR_W-1:0] ADR_SENSOR = ADDR_W'(OFS_SENSOR);
  localparam logic [ADDR_W-1:0] ADR_CAP    = ADDR_W'(OFS_CAP);

  logic [TEMP_W-1:0] tempQ, loThr, hiThr, tripThr;
  logic              loEn, hiEn, polHalf;
  logic              limitsWr;

  assign limitsWr = regWrEn && (regAddr == ADR_LIMITS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempQ   <= '0;
      loThr   <= '0;
      hiThr   <= '0;
      tripThr <= '0;
      loEn    <= 1'b0;
      hiEn    <= 1'b0;
      polHalf <= 1'b0;
    end else begin
      tempQ <= tempIn;
      if (limitsWr) begin
        loThr   <= regWrData[LO_LSB   +: TEMP_W];
        hiThr   <= regWrData[HI_LSB   +: TEMP_W];
        tripThr <= regWrData[TRIP_LSB +: TEMP_W];
        loEn    <= regWrData[LO_EN_BIT];
        hiEn    <= regWrData[HI_EN_BIT];
        polHalf <= regWrData[POL_BIT];
      end
    end
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[63:POL_BIT+1], regWrData[POL_BIT-1:TRIP_LSB+TEMP_W],
                          regWrData[TRIP_LSB-1:HI_EN_BIT+1]};

  assign cmpFlags.loReached   = (tempQ >= loThr);
  assign cmpFlags.hiReached   = (tempQ >= hiThr);
  assign cmpFlags.tripReached = (tripThr != '0) && (tempQ >= tripThr);
  assign cmpFlags.loEnable    = loEn;
  assign cmpFlags.hiEnable    = hiEn;
  assign cmpFlags.policyHalf  = polHalf;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADR_LIMITS: begin
        regRdData[LO_LSB   +: TEMP_W] = loThr;
        regRdData[LO_EN_BIT]          = loEn;
        regRdData[HI_LSB   +: TEMP_W] = hiThr;
        regRdData[HI_EN_BIT]          = hiEn;
        regRdData[TRIP_LSB +: TEMP_W] = tripThr;
        regRdData[LO_ST_BIT]          = cmpFlags.loReached;
        regRdData[HI_ST_BIT]          = cmpFlags.hiReached;
        regRdData[POL_BIT]            = polHalf;
      end
      ADR_SENSOR: regRdData[TEMP_W-1:0] = tempQ;
      ADR_CAP:    regRdData[0]          = NO_THROTTLE;
      default:    regRdData = '0;
    endcase
  end

  // the sample register follows the input with one cycle of delay
  p_sample_delay_r3 : assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (tempQ == $past(tempIn)));
  // fields written at offset 0x08 read back in the next cycle
  p_limit_writeback_r2 : assert property (@(posedge clk) disable iff (!rstN)
    limitsWr |=> (loThr == $past(regWrData[LO_LSB +: TEMP_W])) && (polHalf == $past(regWrData[POL_BIT])));
endmodule

// File: rtl/tht_control.sv
module tht_control
  import tht_pkg::*;
#(
  parameter int WINDOW      = 10,
  parameter int HALF_SLOTS  = 5,
  parameter int HEAVY_SLOTS = 9,
  parameter bit NO_THROTTLE = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  cmpFlags_t cmpFlags,
  output logic      throttleOn,
  output logic      fatalReq
);
  localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] winCnt;
  logic             fatalQ;
  throttleLevel_t   level;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
      fatalQ <= 1'b0;
    end else begin
      winCnt <= (winCnt == LAST_SLOT) ? '0 : winCnt + 1'b1;
      fatalQ <= fatalQ | cmpFlags.tripReached;
    end
  end

  always_comb begin
    level = LVL_NONE;
    if (!NO_THROTTLE) begin
      if (cmpFlags.hiEnable && cmpFlags.hiReached)
        level = LVL_FULL;
      else if (cmpFlags.loEnable && cmpFlags.loReached)
        level = cmpFlags.policyHalf ? LVL_HALF : LVL_HEAVY;
    end
  end

  always_comb begin
    unique case (level)
      LVL_FULL:  throttleOn = 1'b1;
      LVL_HEAVY: throttleOn = (winCnt < CNT_W'(HEAVY_SLOTS));
      LVL_HALF:  throttleOn = (winCnt < CNT_W'(HALF_SLOTS));
      default:   throttleOn = 1'b0;
    endcase
  end

  assign fatalReq = fatalQ | cmpFlags.tripReached;

  p_fatal_sticky_r11 : assert property (@(posedge clk) disable iff (!rstN)
    fatalReq |=> fatalReq);
  p_window_wrap_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (winCnt == LAST_SLOT) |=> (winCnt == '0));
  p_cap_quiet_r5 : assert property (@(posedge clk) disable iff (!rstN)
    NO_THROTTLE |-> !throttleOn);
  p_disabled_quiet_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (!cmpFlags.loEnable && !cmpFlags.hiEnable) |-> !throttleOn);
  p_full_block_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (!NO_THROTTLE && cmpFlags.hiEnable && cmpFlags.hiReached) |-> throttleOn);
endmodule

// File: rtl/therm_throttle.sv
module therm_throttle
  import tht_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WINDOW      = 10,
  parameter int HALF_SLOTS  = 5,
  parameter int HEAVY_SLOTS = 9,
  parameter bit NO_THROTTLE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [6:0]        tempIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output logic              throttleOn,
  output logic              fatalReq
);
  cmpFlags_t cmpFlags;

  tht_datapath #(.ADDR_W(ADDR_W), .NO_THROTTLE(NO_THROTTLE)) uDp (
    .clk(clk), .rstN(rstN), .tempIn(tempIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmpFlags(cmpFlags));

  tht_control #(.WINDOW(WINDOW), .HALF_SLOTS(HALF_SLOTS), .HEAVY_SLOTS(HEAVY_SLOTS),
                .NO_THROTTLE(NO_THROTTLE)) uCtl (
    .clk(clk), .rstN(rstN), .cmpFlags(cmpFlags), .throttleOn(throttleOn), .fatalReq(fatalReq));
endmodule

// File: tb/sim_therm_throttle.sv
`timescale 1ns/1ps
module sim_therm_throttle;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  tempIn = '0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = 6'h08;
  logic [63:0] regWrData = '0;
  logic [63:0] rd0, rd1;
  logic        thr0, thr1, fat0, fat1;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  therm_throttle u0 (.clk(clk), .rstN(rstN), .tempIn(tempIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rd0), .throttleOn(thr0), .fatalReq(fat0));
  therm_throttle #(.NO_THROTTLE(1'b1)) u1 (.clk(clk), .rstN(rstN), .tempIn(tempIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rd1), .throttleOn(thr1), .fatalReq(fat1));

  typedef struct packed {
    logic [6:0] lo; logic loEn; logic [6:0] hi; logic hiEn; logic pol;
    logic [6:0] temp; logic stLo; logic stHi; logic [3:0] blocked;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{7'd40, 1'b1, 7'd60, 1'b1, 1'b0, 7'd30, 1'b0, 1'b0, 4'd0},   // below both
    '{7'd40, 1'b1, 7'd60, 1'b1, 1'b0, 7'd40, 1'b1, 1'b0, 4'd9},   // R6 equal to lower
    '{7'd40, 1'b1, 7'd60, 1'b1, 1'b1, 7'd50, 1'b1, 1'b0, 4'd5},   // R7
    '{7'd40, 1'b1, 7'd60, 1'b1, 1'b1, 7'd60, 1'b1, 1'b1, 4'd10},  // R8 equal to upper
    '{7'd40, 1'b0, 7'd60, 1'b0, 1'b0, 7'd70, 1'b1, 1'b1, 4'd0},   // R9 both disabled
    '{7'd40, 1'b1, 7'd60, 1'b0, 1'b0, 7'd70, 1'b1, 1'b1, 4'd9},   // R9 upper disabled
    '{7'd40, 1'b0, 7'd60, 1'b1, 1'b1, 7'd50, 1'b1, 1'b0, 4'd0},   // R9 lower disabled
    '{7'd0,  1'b1, 7'd60, 1'b1, 1'b1, 7'd0,  1'b1, 1'b0, 4'd5},   // R7 zero limit
    '{7'd40, 1'b1, 7'd60, 1'b1, 1'b0, 7'd39, 1'b0, 1'b0, 4'd0}    // R3 one below
  };

  function automatic logic [63:0] limits(input logic [6:0] lo, input logic loEn, input logic [6:0] hi,
                                         input logic hiEn, input logic [6:0] trip, input logic pol);
    logic [63:0] v = '0;
    v[6:0] = lo; v[7] = loEn; v[14:8] = hi; v[15] = hiEn; v[30:24] = trip; v[44] = pol;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [63:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 6'h08;
  endtask

  task automatic countBlocked(output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < 10; i++) begin
      c0 += int'(thr0); c1 += int'(thr1);
      @(negedge clk);
    end
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish();
    end
  end

  initial begin
    int c0, c1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: limits zero; live flags read 1 because temperature 0 >= limit 0
    regAddr = 6'h08; #1;
    check(rd0 == 64'h3_0000_0000, "R1 reset limits", rd0, 64'h3_0000_0000);
    check(!thr0 && !fat0, "R1 reset outputs", {thr0, fat0}, 0);

    // R2 field readback, status and reserved bits not writable
    tempIn = 7'd30; @(negedge clk);
    regWrite(6'h08, '1);
    #1; check(rd0 == 64'h0000_1000_7F00_FFFF, "R2 readback", rd0, 64'h0000_1000_7F00_FFFF);
    // R4 sensor readout and ignored writes
    regWrite(6'h10, '1);
    regAddr = 6'h10; #1;
    check(rd0 == 64'd30, "R4 sensor", rd0, 64'd30);
    // R5 capability, ignored writes
    regWrite(6'h20, '1);
    regAddr = 6'h20; #1;
    check(rd0 == 64'd0, "R5 cap u0", rd0, 0);
    check(rd1 == 64'd1, "R5 cap u1", rd1, 1);
    regAddr = 6'h08;

    // table walk
    for (int v = 0; v < NV; v++) begin
      regWrite(6'h08, limits(VECS[v].lo, VECS[v].loEn, VECS[v].hi, VECS[v].hiEn, 7'd0, VECS[v].pol));
      tempIn = VECS[v].temp;
      repeat (2) @(negedge clk);
      regAddr = 6'h08; #1;
      check(rd0[33:32] == {VECS[v].stHi, VECS[v].stLo}, $sformatf("R3 status vec%0d", v),
            rd0[33:32], {VECS[v].stHi, VECS[v].stLo});
      countBlocked(c0, c1);
      check(c0 == int'(VECS[v].blocked), $sformatf("R6/R7/R8/R9 duty vec%0d", v), c0, VECS[v].blocked);
      check(c1 == 0, $sformatf("R5 no-throttle vec%0d", v), c1, 0);
      check(!fat0, $sformatf("R10 zero trip vec%0d", v), fat0, 0);
    end

    // R3 timing: flag changes exactly one cycle after the sample
    regWrite(6'h08, limits(7'd40, 1'b1, 7'd60, 1'b1, 7'd0, 1'b0));
    tempIn = 7'd20; repeat (2) @(negedge clk);
    tempIn = 7'd45; #1;
    check(rd0[32] == 1'b0, "R3 before edge", rd0[32], 0);
    @(negedge clk); #1;
    check(rd0[32] == 1'b1, "R3 after edge", rd0[32], 1);
    tempIn = 7'd20; @(negedge clk); #1;
    check(rd0[32] == 1'b0, "R3 no latch", rd0[32], 0);

    // R10 zero trip at maximum temperature
    tempIn = 7'd127; repeat (2) @(negedge clk);
    check(!fat0, "R10 trip zero disabled", fat0, 0);
    tempIn = 7'd20; @(negedge clk);
    regWrite(6'h08, limits(7'd40, 1'b1, 7'd60, 1'b1, 7'd80, 1'b0));
    tempIn = 7'd79; repeat (2) @(negedge clk);
    check(!fat0, "R10 below trip", fat0, 0);
    tempIn = 7'd20; repeat (2) @(negedge clk);
    // trip and full throttle in the same cycle
    tempIn = 7'd80; #1;
    check(!fat0 && !thr0, "R10 not early", {fat0, thr0}, 0);
    @(negedge clk);
    check(fat0, "R10 trip rise", fat0, 1);
    check(thr0, "R8 with trip", thr0, 1);
    countBlocked(c0, c1);
    check(c0 == 10, "R8 full window with trip", c0, 10);
    tempIn = 7'd20; repeat (2) @(negedge clk);
    check(fat0, "R11 sticky", fat0, 1);
    countBlocked(c0, c1);
    check(c0 == 0, "R8 release", c0, 0);
    rstN = 1'b0; @(negedge clk);
    rstN = 1'b1; @(negedge clk);
    check(!fat0, "R11 cleared by reset", fat0, 0);
    regAddr = 6'h08; #1;
    check(rd0[30:0] == 31'd0 && rd0[44] == 1'b0, "R1 limits after reset", rd0, 0);

    done = 1'b1;
    finish();
  end
endmodule